// File: doc/BRIEF.md
# Maskable Interrupt Acceptance Unit

This unit decides in which clock the execution core takes a maskable interrupt. The interrupt pin is asynchronous and level sensitive. The unit passes it through a short flip-flop synchronizer. It looks at the synchronized level only in the final clock of an instruction, or in the final clock of one pass of a repeated string move, and only while the core's interrupt-enable flag is set. When all of these hold, it raises a one-clock take pulse. The core uses that pulse to hold back the next instruction. In the next clock the unit raises a vector-start pulse, which opens the clock spent vectoring into service.

Nothing is latched. A request that has dropped again by the time its synchronized copy would be looked at is simply lost. A request that comes too late for one boundary is considered again at the next boundary, as long as the pin is still high. An instruction-timing model supplies two boundary strobes, one for instruction ends and one for string-iteration ends. Each strobe may be sent a fixed number of clocks ahead of the final clock. The unit delays the strobe so that it lines up with that final clock.

Top module: `irq_accept`

## Requirements
- R1: The pin reaches the decision logic through two flip-flop stages. With the default parameters, `irq_take` in clock n depends on the pin level sampled at the end of clock n-2.
- R2: The request is not latched. If the pin goes low again before its synchronized copy is looked at in a boundary clock, no take occurs.
- R3: A take happens only in a boundary clock, meaning a clock in which `instr_end` or `iter_end` is high (default lead 0: the strobe is high during the final clock). Both strobes have the same effect.
- R4: While `int_en` is low in the boundary clock, no take occurs whatever the pin does.
- R5: A pin that goes high three or more clocks before the end of an instruction (counting the final clock) is taken in that instruction's final clock. A pin that goes high only two clocks before the end is not taken at that boundary.
- R6: A request that missed a boundary is taken at the next boundary if the pin is still high.
- R7: `irq_take` is high for exactly one clock. `vec_start` is high for one clock, in the clock right after each take and at no other time.
- R8: A boundary strobe that falls in the vectoring clock (the clock in which `vec_start` is high) is ignored, even with the pin high and `int_en` set.
- R9: If the pin stays high and `int_en` stays set, `vec_start` comes no more than (longest instruction length + 3) clocks after the clock in which the pin rose.
- R10: Synchronous active-low reset clears both synchronizer stages and the vectoring state. For the two clocks after reset is released, no take occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_pin | input | 1 | Raw maskable interrupt pin, asynchronous, active high |
| int_en | input | 1 | Interrupt-enable flag of the core |
| instr_end | input | 1 | Instruction-end strobe, BND_LEAD clocks before the final clock |
| iter_end | input | 1 | String-iteration-end strobe, same timing |
| irq_take | output | 1 | One-clock take pulse; blocks the next instruction |
| vec_start | output | 1 | One-clock start of vectoring, the clock after a take |

## Verification
The bench places the pin's rising edge two, three and four clocks ahead of a boundary. A design with one stage too many or too few in the synchronizer would move the acceptance point by one instruction. The bench also raises the pin briefly and drops it before the boundary; a design that latched requests would take that interrupt anyway. It places a one-clock instruction straight after a take, where a design that did not block the vectoring clock would produce two takes back to back. It also asserts reset while the pin is high, to catch stale synchronizer contents. Random pin, enable and instruction-length stimulus is compared, clock by clock, with a bench model of the requirements, and every held request is checked against the latency bound.

// File: rtl/irqa_pkg.sv
// Package: shared types and helpers of the maskable interrupt acceptance unit.
// Assumes: nothing beyond IEEE 1800-2017.
package irqa_pkg;

    // Decision phase: running instructions, or spending clocks on vectoring.
    typedef enum logic {
        PH_RUN = 1'b0,
        PH_VEC = 1'b1
    } phase_e;

    // Clocks the pin must lead the instruction end, final clock included.
    function automatic int unsigned setup_clocks(input int unsigned stages);
        return stages + 1;
    endfunction

endpackage

// File: rtl/irqa_sync.sv
// Module: irqa_sync
// Moves an asynchronous level into the clock domain through a chain of
// STAGES flip-flops. Assumes STAGES >= 1. Reset clears every stage.
module irqa_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_chain
            // Purpose: shift the pin level along the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/irqa_bnd_align.sv
// Module: irqa_bnd_align
// Merges the instruction-end and iteration-end strobes and delays them by
// LEAD clocks. The timing model sends them LEAD clocks before the final
// clock, so the output is high exactly in the final clock.
// Assumes the strobes are synchronous to clk.
module irqa_bnd_align #(
    parameter int unsigned LEAD = 0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_end,
    input  logic iter_end,
    output logic bnd_now
);

    logic strobe;

    // Purpose: either kind of boundary counts the same.
    always_comb strobe = instr_end | iter_end;

    generate
        if (LEAD == 0) begin : g_direct
            assign bnd_now = strobe;
        end else if (LEAD == 1) begin : g_one
            logic pipe_q;
            // Purpose: one-clock alignment delay.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= 1'b0;
                else        pipe_q <= strobe;
            end
            assign bnd_now = pipe_q;
        end else begin : g_many
            logic [LEAD-1:0] pipe_q;
            // Purpose: LEAD-clock alignment delay line.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe_q <= '0;
                else        pipe_q <= {pipe_q[LEAD-2:0], strobe};
            end
            assign bnd_now = pipe_q[LEAD-1];
        end
    endgenerate

endmodule

// File: rtl/irqa_decide.sv
// Module: irqa_decide
// Decides acceptance in a boundary clock and sequences the vectoring clocks.
// The take output is combinational, so it can stop the next instruction in
// the same clock. While vectoring, boundaries are ignored.
// Assumes VEC_CLKS >= 1.
module irqa_decide
    import irqa_pkg::*;
#(
    parameter int unsigned VEC_CLKS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    input  logic int_en,
    input  logic bnd_now,
    output logic take,
    output logic vec_start
);

    localparam int unsigned CW = (VEC_CLKS > 1) ? $clog2(VEC_CLKS) : 1;

    phase_e        phase_q;
    logic [CW-1:0] cnt_q;
    logic          vec_q;

    // Purpose: accept only in a boundary clock, enabled, request present, not vectoring.
    always_comb take = (phase_q == PH_RUN) && bnd_now && int_en && req_sync;

    // Purpose: vectoring phase counter and vector-start pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
            vec_q   <= 1'b0;
        end else begin
            vec_q <= take;
            case (phase_q)
                PH_RUN: begin
                    if (take) begin
                        phase_q <= PH_VEC;
                        cnt_q   <= CW'(VEC_CLKS - 1);
                    end
                end
                default: begin
                    if (cnt_q == '0) phase_q <= PH_RUN;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    assign vec_start = vec_q;

endmodule

// File: rtl/irq_accept.sv
// Module: irq_accept (top)
// Maskable interrupt acceptance: a synchronizer, boundary alignment and the
// accept/vector decision. Assumes the pin is asynchronous and the boundary
// strobes are synchronous and arrive BND_LEAD clocks ahead of the final clock.
module irq_accept #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned BND_LEAD    = 0,
    parameter int unsigned VEC_CLKS    = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_pin,
    input  logic int_en,
    input  logic instr_end,
    input  logic iter_end,
    output logic irq_take,
    output logic vec_start
);

    logic req_sync;
    logic bnd_now;

    irqa_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (irq_pin),
        .sync_out (req_sync)
    );

    irqa_bnd_align #(.LEAD(BND_LEAD)) u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr_end (instr_end),
        .iter_end  (iter_end),
        .bnd_now   (bnd_now)
    );

    irqa_decide #(.VEC_CLKS(VEC_CLKS)) u_decide (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .int_en    (int_en),
        .bnd_now   (bnd_now),
        .take      (irq_take),
        .vec_start (vec_start)
    );

endmodule

// File: rtl/irqa_checker.sv
// Module: irqa_checker
// Temporal checks on irq_accept, attached with bind.
// Assumes VEC_CLKS >= 1; the synchronizer delay check applies to two stages.
module irqa_checker #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input logic clk,
    input logic rst_n,
    input logic irq_pin,
    input logic int_en,
    input logic bnd_now,
    input logic irq_take,
    input logic vec_start
);

    generate
        if (SYNC_STAGES == 2) begin : g_two
            // R1: a take needs the pin high two clocks earlier.
            assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
                irq_take |-> $past(irq_pin, 2));
        end
    endgenerate

    // R3: a take only in an aligned boundary clock.
    assert_boundary_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> bnd_now);

    // R4: no take while interrupts are disabled.
    assert_masked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !int_en |-> !irq_take);

    // R7: the take pulse lasts one clock.
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    // R7: vectoring starts the clock after a take.
    assert_vec_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> vec_start);

    // R7: vec_start only after a take.
    assert_vec_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_start |-> $past(irq_take));

    // R8: no take in the vectoring clock.
    assert_vec_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        vec_start |-> !irq_take);

    // R10: reset leaves both outputs low in the following clock.
    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |=> (!irq_take && !vec_start));

endmodule

bind irq_accept irqa_checker #(.SYNC_STAGES(SYNC_STAGES)) u_irqa_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_pin   (irq_pin),
    .int_en    (int_en),
    .bnd_now   (bnd_now),
    .irq_take  (irq_take),
    .vec_start (vec_start)
);

// File: tb/test_irq_accept.sv
`timescale 1ns/1ps
// Bench for irq_accept with its default parameters: directed corner cases
// followed by seeded random stimulus, compared against a requirement model.
module test_irq_accept;

    localparam int LONGEST = 8;

    logic clk = 1'b0;
    logic rst_n, irq_pin, int_en, instr_end, iter_end;
    logic irq_take, vec_start;

    int checks = 0;
    int errors = 0;
    int stepno = 0;
    bit done   = 1'b0;

    // Model state: pin one and two steps back, previous expected take.
    logic p1 = 1'b0, p2 = 1'b0, prev_take = 1'b0;
    logic obs_take;
    // Latency tracker.
    bit   trk_on = 1'b0;
    int   trk_start = 0;
    logic prev_pin = 1'b0;

    irq_accept i_irq_accept (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_pin   (irq_pin),
        .int_en    (int_en),
        .instr_end (instr_end),
        .iter_end  (iter_end),
        .irq_take  (irq_take),
        .vec_start (vec_start)
    );

    always #2 clk = ~clk;

    function automatic int instr_len(input int idx);
        return 1 + ((idx * 5 + 3) % LONGEST);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s step %0d actual %0d expected %0d", req, stepno, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, compare just before the rising edge.
    task automatic step(input logic r, input logic p, input logic e, input logic ie, input logic se);
        logic exp_take;
        string tag;
        @(negedge clk);
        rst_n = r; irq_pin = p; int_en = e; instr_end = ie; iter_end = se;
        #1;
        stepno++;
        exp_take = r & (ie | se) & e & p2 & !prev_take;
        if (!r)              tag = "R10";
        else if (!e)         tag = "R4";
        else if (!(ie | se)) tag = "R3";
        else if (prev_take)  tag = "R8";
        else                 tag = "R1";
        check(irq_take === exp_take, tag, int'(irq_take), int'(exp_take));
        check(vec_start === prev_take, "R7", int'(vec_start), int'(prev_take));
        obs_take = irq_take;
        // R9 latency tracking
        if (r && vec_start && trk_on) begin
            check((stepno - trk_start) <= LONGEST + 3, "R9", stepno - trk_start, LONGEST + 3);
            trk_on = 1'b0;
        end
        if (!r || !p || !e) trk_on = 1'b0;
        else if (p && !prev_pin) begin
            trk_on = 1'b1;
            trk_start = stepno;
        end
        prev_pin = r ? p : 1'b0;
        if (!r) begin
            p2 = 1'b0; p1 = 1'b0; prev_take = 1'b0;
        end else begin
            p2 = p1; p1 = p; prev_take = exp_take;
        end
    endtask

    // Directed: pin rises `lead` clocks before the end of a 6-clock instruction
    // and is held through a following 4-clock instruction.
    task automatic lead_case(input int lead, input bit use_iter, output logic t_first, output logic t_second);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);
        for (int i = 0; i < 10; i++) begin
            logic pin;
            logic bnd;
            pin = (i >= 6 - lead);
            bnd = (i == 5) || (i == 9);
            step(1, pin, 1, bnd & !use_iter, bnd & use_iter);
            if (i == 5) t_first = obs_take;
            if (i == 9) t_second = obs_take;
        end
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired at step %0d actual 0 expected 1", stepno);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic a, b;
        void'($urandom(32'h5EED_1234));
        rst_n = 0; irq_pin = 0; int_en = 0; instr_end = 0; iter_end = 0;
        // R10: reset state
        for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0);
        check(irq_take === 1'b0 && vec_start === 1'b0, "R10", int'(irq_take), 0);

        // R5: three and four clocks of lead are accepted at the first boundary
        lead_case(3, 0, a, b);
        check(a === 1'b1, "R5 lead 3", int'(a), 1);
        lead_case(4, 0, a, b);
        check(a === 1'b1, "R5 lead 4", int'(a), 1);
        // R5/R6: two clocks of lead miss, next boundary takes it
        lead_case(2, 0, a, b);
        check(a === 1'b0, "R5 lead 2", int'(a), 0);
        check(b === 1'b1, "R6 next boundary", int'(b), 1);
        // R3: iteration strobe behaves like the instruction strobe
        lead_case(3, 1, a, b);
        check(a === 1'b1, "R3 iteration boundary", int'(a), 1);

        // R2: short pulse dropped before the boundary is lost
        for (int i = 0; i < 6; i++) begin
            step(1, (i == 1 || i == 2), 1, (i == 5), 0);
            if (i == 5) check(obs_take === 1'b0, "R2 dropped pulse", int'(obs_take), 0);
        end
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);

        // R4: disabled at the boundary
        for (int i = 0; i < 6; i++) begin
            step(1, 1, (i != 5), (i == 5), 0);
            if (i == 5) check(obs_take === 1'b0, "R4 disabled", int'(obs_take), 0);
        end
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);

        // R8: boundary in the vectoring clock is ignored, the next one is taken
        for (int i = 0; i < 8; i++) begin
            step(1, 1, 1, (i >= 5), 0);
            if (i == 5) check(obs_take === 1'b1, "R8 first take", int'(obs_take), 1);
            if (i == 6) check(obs_take === 1'b0, "R8 vectoring clock", int'(obs_take), 0);
            if (i == 7) check(obs_take === 1'b1, "R8 after vectoring", int'(obs_take), 1);
        end
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);

        // R10: reset with the pin high, boundaries right after release
        for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 0);
        step(0, 1, 1, 0, 0);
        step(1, 1, 1, 1, 0);
        check(obs_take === 1'b0, "R10 after release +0", int'(obs_take), 0);
        step(1, 1, 1, 1, 0);
        check(obs_take === 1'b0, "R10 after release +1", int'(obs_take), 0);
        step(1, 1, 1, 1, 0);
        check(obs_take === 1'b1, "R10 after release +2", int'(obs_take), 1);
        for (int i = 0; i < 4; i++) step(1, 0, 1, 0, 0);

        // Random: table-driven instruction lengths, random pin and enable.
        begin
            int remain   = instr_len(0);
            int idx      = 0;
            int pin_left = 3;
            logic pin    = 1'b0;
            logic en     = 1'b1;
            for (int c = 0; c < 20000; c++) begin
                logic bnd, use_iter;
                if (pin_left == 0) begin
                    pin = !pin;
                    pin_left = 1 + int'($urandom % (pin ? 12 : 6));
                end
                pin_left--;
                if (($urandom % 16) == 0) en = !en;
                if (($urandom % 4) != 0 && !en) en = 1'b1;
                remain--;
                bnd = (remain == 0);
                use_iter = ($urandom % 3) == 0;
                step(1, pin, en, bnd & !use_iter, bnd & use_iter);
                if (bnd) begin
                    idx = int'($urandom % 16);
                    remain = instr_len(idx);
                end
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule